// File: doc/BRIEF.md
# I2C DAC Update Slave

This block is the digital front end of a single-channel 8-bit voltage DAC that is written over a two-wire serial bus. It samples the bus clock and data lines with its own system clock and finds START, repeated START and STOP conditions. It then matches a 7-bit write address, or a broadcast address, and acknowledges by pulling the data line low through an open-drain enable. After a write is accepted, it joins each pair of data bytes into a 2-bit power-down mode and an 8-bit code.

A new code and mode appear together with a one-cycle `update` strobe. They change only at the end of the acknowledge for the second byte of a pair. A host can stream any number of pairs after one address. The block also recognises the high-speed master code and reports it on `hs_mode`. The code holds zero from reset until the first complete word arrives.

Top module: `i2c_dac_slave`

## Requirements
- R1: After reset `dac_code` is 0, `pd_mode` is 0, and `update`, `sda_oe` and `hs_mode` are all low.
- R2: An address byte whose upper seven bits are 1,0,0,1,1,0,A0 and whose last bit (R/W) is 0 is acknowledged. A0 is the value of `a0_pin` while reset is asserted, so later changes on the pin have no effect.
- R3: The broadcast address byte 0x90 is acknowledged whatever A0 is, and the words that follow it are handled exactly like a direct write.
- R4: An address byte that matches neither address, or that has R/W = 1, is not acknowledged. Every byte after it is also ignored, with no acknowledge and no update, until the next START or repeated START.
- R5: In the first byte of a pair, bits 5:4 set `pd_mode` (bit 5 is the upper mode bit) and bits 3:0 set `dac_code[7:4]`. In the second byte, bits 7:4 set `dac_code[3:0]` and bits 3:0 are ignored.
- R6: Every data byte of an accepted write is acknowledged: `sda_oe` is high during the high phase of the ninth clock pulse.
- R7: The code and mode commit, and `update` pulses for exactly one cycle, after the falling SCL edge that ends the acknowledge of the second byte. The first byte alone causes no update.
- R8: Further byte pairs in the same transfer each produce one more update, with no new START or address.
- R9: A STOP or repeated START between the two bytes of a pair throws away the partial word. No update fires for it, and the next byte after a new address is treated as a first byte.
- R10: A byte of the form 00001xxx in the address slot is not acknowledged and sets `hs_mode`. `hs_mode` stays set across repeated STARTs and is cleared by a STOP.
- R11: `dac_code` and `pd_mode` hold their values in every cycle in which `update` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset; A0 is captured while it is low |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low (open-drain acknowledge) |
| a0_pin | input | 1 | Address select bit |
| dac_code | output | 8 | Committed DAC code |
| pd_mode | output | 2 | Committed power-down mode; 0 is normal operation |
| update | output | 1 | One-cycle strobe when code and mode commit |
| hs_mode | output | 1 | High-speed master code seen since the last STOP |

## Verification
The main path is driven with one long transfer that streams every 8-bit code. The power-down mode cycles through all four values, and the ignored low nibble of the second byte carries changing junk. This separates swapped or misaligned nibbles, mode bits taken from the wrong positions, and leakage from the ignored bits. Words cut off by a STOP, or by a repeated START, show whether the pair counter is cleared, because a stale half-word would shift every later code. Foreign addresses, read requests, the broadcast address, a change on the A0 pin after reset, and the high-speed master code followed by a repeated START each check one branch of the address decision, the acknowledge line and the `hs_mode` flag.

// File: rtl/i2c_dac_slave.sv
module i2c_dac_slave #(
  parameter logic [5:0] ADDR_PREFIX = 6'b100110,
  parameter logic [6:0] BCAST_ADDR  = 7'b1001000,
  parameter logic [4:0] HS_PREFIX   = 5'b00001,
  parameter int         SYNC_N      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic       a0_pin,
  output logic [7:0] dac_code,
  output logic [1:0] pd_mode,
  output logic       update,
  output logic       hs_mode
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_ACK, S_SKIP} st_t;

  logic [SYNC_N-1:0] scl_sr, sda_sr;
  logic scl_d, sda_d, a0_q;
  st_t st;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic half, commit_pend;
  logic [1:0] pend_pd;
  logic [3:0] pend_hi;

  wire scl  = scl_sr[SYNC_N-1];
  wire sda  = sda_sr[SYNC_N-1];
  wire start_c  = scl && scl_d && sda_d && !sda;
  wire stop_c   = scl && scl_d && !sda_d && sda;
  wire scl_rise = scl && !scl_d;
  wire scl_fall = !scl && scl_d;
  wire addr_hit = !shreg[0] &&
                  (shreg[7:1] == {ADDR_PREFIX, a0_q} || shreg[7:1] == BCAST_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1; sda_sr <= '1;
      scl_d <= 1'b1; sda_d <= 1'b1;
      a0_q <= a0_pin;
      st <= S_IDLE;
      bit_cnt <= '0; shreg <= '0;
      half <= 1'b0; commit_pend <= 1'b0;
      pend_pd <= '0; pend_hi <= '0;
      sda_oe <= 1'b0; update <= 1'b0; hs_mode <= 1'b0;
      dac_code <= '0; pd_mode <= '0;
    end else begin
      scl_sr <= {scl_sr[SYNC_N-2:0], scl_in};
      sda_sr <= {sda_sr[SYNC_N-2:0], sda_in};
      scl_d <= scl;
      sda_d <= sda;
      update <= 1'b0;
      if (stop_c) begin
        st <= S_IDLE; hs_mode <= 1'b0; sda_oe <= 1'b0; commit_pend <= 1'b0;
      end else if (start_c) begin
        st <= S_ADDR; bit_cnt <= '0; half <= 1'b0; sda_oe <= 1'b0; commit_pend <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_DATA: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              if (st == S_ADDR) begin
                if (shreg[7:3] == HS_PREFIX) begin
                  hs_mode <= 1'b1; st <= S_SKIP;
                end else if (addr_hit) begin
                  sda_oe <= 1'b1; st <= S_ACK; commit_pend <= 1'b0;
                end else
                  st <= S_SKIP;
              end else begin
                sda_oe <= 1'b1; st <= S_ACK;
                if (!half) begin
                  pend_pd <= shreg[5:4]; pend_hi <= shreg[3:0];
                  half <= 1'b1; commit_pend <= 1'b0;
                end else begin
                  half <= 1'b0; commit_pend <= 1'b1;
                end
              end
            end
          end
          S_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            st <= S_DATA;
            if (commit_pend) begin
              dac_code <= {pend_hi, shreg[7:4]};
              pd_mode <= pend_pd;
              update <= 1'b1;
              commit_pend <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_dac_slave_chk.sv
module i2c_dac_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_in,
  input logic       sda_oe,
  input logic       update,
  input logic [7:0] dac_code,
  input logic [1:0] pd_mode,
  input logic       hs_mode
);
  // R7
  update_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> !update);
  // R7
  update_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update |-> !sda_oe);
  // R11
  output_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !update |-> ($stable(dac_code) && $stable(pd_mode)));
  // R10
  hs_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode) |-> !sda_oe);
  // R6
  ack_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_in);
endmodule

bind i2c_dac_slave i2c_dac_slave_chk u_chk (.*);

// File: tb/sim_i2c_dac_slave.sv
module sim_i2c_dac_slave;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, a0 = 1'b0;
  logic sda_oe, update, hs_mode;
  logic [7:0] dac_code;
  logic [1:0] pd_mode;
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_err = 0, upd_cnt = 0, wide_err = 0;
  logic [7:0] last_code = '0;
  logic [1:0] last_pd = '0;
  logic upd_prev = 1'b0;

  always #5 clk = ~clk;

  i2c_dac_slave u0 (.clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .a0_pin(a0), .dac_code(dac_code), .pd_mode(pd_mode),
    .update(update), .hs_mode(hs_mode));

  always @(negedge clk) begin
    if (update) begin
      upd_cnt <= upd_cnt + 1;
      last_code <= dac_code;
      last_pd <= pd_mode;
      if (upd_prev) wide_err <= wide_err + 1;
    end
    upd_prev <= update;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(4); scl = 1'b1; wt(4); sda_m = 1'b0; wt(4); scl = 1'b0; wt(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(4); scl = 1'b1; wt(4); sda_m = 1'b1; wt(8);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(4); scl = 1'b1; wt(8); scl = 1'b0; wt(4);
    end
    sda_m = 1'b1; wt(4); scl = 1'b1; wt(4);
    ack = sda_oe && !sda_line;
    wt(4); scl = 1'b0; wt(4);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wt(5); rst_n = 1'b1; wt(2);
  endtask

  logic ack;
  int c0;
  logic [7:0] code;
  logic [1:0] pd;
  logic [7:0] prev;

  initial begin
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    chk(dac_code == 0 && pd_mode == 0, "R1 code/mode", {pd_mode, dac_code}, 0);
    chk(!update && !sda_oe && !hs_mode, "R1 flags", {update, sda_oe, hs_mode}, 0);

    // R2 R5 R6 R7 R8: full code sweep in one transfer
    bus_start();
    send_byte(8'h98, ack);
    chk(ack, "R2 direct addr ack", ack, 1);
    for (int i = 0; i < 256; i++) begin
      code = 8'(i) ^ 8'h5C;
      pd = 2'(i);
      c0 = upd_cnt;
      send_byte({2'b00, pd, code[7:4]}, ack);
      chk(ack, "R6 first byte ack", ack, 1);
      chk(upd_cnt == c0, "R7 no update after first byte", upd_cnt - c0, 0);
      send_byte({code[3:0], 4'(i) ^ 4'hF}, ack);
      chk(ack, "R6 second byte ack", ack, 1);
      chk(upd_cnt == c0 + 1, "R8 one update per pair", upd_cnt - c0, 1);
      chk(dac_code == code && last_code == code, "R5 code", dac_code, code);
      chk(pd_mode == pd && last_pd == pd, "R5 mode", pd_mode, pd);
    end
    bus_stop();
    chk(wide_err == 0, "R7 strobe width", wide_err, 0);

    // R9: partial word cut by STOP, then by repeated START
    prev = dac_code; c0 = upd_cnt;
    bus_start(); send_byte(8'h98, ack); send_byte(8'h3F, ack); bus_stop();
    chk(upd_cnt == c0 && dac_code == prev, "R9 stop discards", dac_code, prev);
    bus_start(); send_byte(8'h98, ack); send_byte(8'h12, ack);
    bus_start(); send_byte(8'h98, ack);
    send_byte(8'h21, ack);
    chk(upd_cnt == c0, "R9 sr discards", upd_cnt - c0, 0);
    send_byte(8'hB0, ack);
    chk(upd_cnt == c0 + 1 && dac_code == 8'h1B && pd_mode == 2'd2, "R9 realigned", {pd_mode, dac_code}, 10'h21B);
    bus_stop();

    // R4: foreign address and read request
    prev = dac_code; c0 = upd_cnt;
    bus_start(); send_byte(8'h9A, ack);
    chk(!ack, "R4 foreign addr nack", ack, 0);
    send_byte(8'h00, ack); chk(!ack, "R4 data ignored", ack, 0);
    send_byte(8'h00, ack); chk(!ack, "R4 data ignored", ack, 0);
    bus_stop();
    bus_start(); send_byte(8'h99, ack);
    chk(!ack, "R4 read nack", ack, 0);
    send_byte(8'h2A, ack); send_byte(8'h50, ack);
    chk(!ack, "R4 read data ignored", ack, 0);
    bus_stop();
    chk(upd_cnt == c0 && dac_code == prev, "R4 no update", dac_code, prev);

    // R3: broadcast
    bus_start(); send_byte(8'h90, ack);
    chk(ack, "R3 broadcast ack", ack, 1);
    send_byte(8'h2A, ack); send_byte(8'h5F, ack);
    chk(dac_code == 8'hA5 && pd_mode == 2'd2, "R3 broadcast word", {pd_mode, dac_code}, 10'h2A5);
    bus_stop();

    // R10: high-speed master code
    bus_start(); send_byte(8'h0D, ack);
    chk(!ack, "R10 hs code nack", ack, 0);
    chk(hs_mode, "R10 hs set", hs_mode, 1);
    bus_start();
    chk(hs_mode, "R10 hs across sr", hs_mode, 1);
    send_byte(8'h98, ack); send_byte(8'h07, ack); send_byte(8'hC3, ack);
    chk(dac_code == 8'h7C && pd_mode == 2'd0, "R10 write in hs", {pd_mode, dac_code}, 10'h07C);
    chk(hs_mode, "R10 hs held", hs_mode, 1);
    bus_stop();
    chk(!hs_mode, "R10 hs cleared by stop", hs_mode, 0);

    // R2: A0 latched at reset only
    a0 = 1'b1; wt(4);
    bus_start(); send_byte(8'h9A, ack);
    chk(!ack, "R2 a0 not resampled", ack, 0);
    bus_stop();
    do_reset();
    chk(dac_code == 0 && pd_mode == 0 && !hs_mode, "R1 second reset", {pd_mode, dac_code}, 0);
    bus_start(); send_byte(8'h9A, ack);
    chk(ack, "R2 a0=1 ack", ack, 1);
    bus_stop();
    bus_start(); send_byte(8'h98, ack);
    chk(!ack, "R2 a0=1 rejects a0=0", ack, 0);
    bus_stop();
    bus_start(); send_byte(8'h90, ack);
    chk(ack, "R3 broadcast with a0=1", ack, 1);
    send_byte(8'h3E, ack); send_byte(8'hD7, ack);
    chk(dac_code == 8'hED && pd_mode == 2'd3, "R3 broadcast word a0=1", {pd_mode, dac_code}, 10'h3ED);
    bus_stop();
    chk(wide_err == 0, "R7 strobe width final", wide_err, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule